// File: doc/BRIEF.md
# Transmit Cell Rate Shaper and Arbiter

This block decides, once per transmit cell slot, which of four source ports hands the next ATM cell to the line, or whether the slot carries an idle cell. The line side raises `slot_req` for one clock whenever it has a slot to fill. The sources show which of them hold a complete cell on `cell_avail`. One clock later the block answers with `grant_valid`, together with either a port index or the idle marker.

Each port has two configuration values. The first is a priority level; the larger level wins. The second is an 8-bit rate value that caps the port's share of slots at rate/256. The rate cap uses one 8-bit credit accumulator per port. On every slot the accumulator adds the port's rate. The port may be chosen in that slot only if the addition carries out. Ports at the same level are served round-robin, and each level has its own pointer.

A counter per port records the non-idle cells granted to that port. A read clears the counter. A sticky flag marks a counter that has wrapped, and the same read clears that flag.

Top module: `tx_cell_sched`

## Requirements
- R1: After reset, `grant_valid` is 0, every counter reads 0, every `cnt_ovf` bit is 0, every credit accumulator is 0 and every round-robin pointer is at port 0.
- R2: `grant_valid` is 1 in the cycle after a cycle with `slot_req` = 1, and 0 in the cycle after a cycle with `slot_req` = 0.
- R3: On each slot, every port's accumulator becomes (acc + rate) mod 256. The port is eligible in that slot only when acc + rate >= 256. Starting from reset, a port with rate r that always has a cell is granted exactly r times in 256 slots, so rate 0 is never granted.
- R4: A port is a candidate when it is eligible and its `cell_avail` bit is 1. The winner is a candidate, and no candidate has a higher priority field than the winner. Port p's priority is `port_prio[2p+1:2p]`.
- R5: Among candidates at the winning level, the search starts at that level's pointer and moves upward modulo 4. The first candidate found wins, and the pointer then moves to winner+1 mod 4.
- R6: A level's pointer changes only when a port at that level is granted.
- R7: When a slot has no candidate, the answer is `grant_idle` = 1.
- R8: Each non-idle grant adds one to the granted port's counter. Idle slots change no counter.
- R9: When `cnt_rd_en` = 1, `cnt_rd_data` shows counter `cnt_rd_sel`, and that counter is 0 after the clock edge. If a grant to the same port is being counted at that same edge, the counter is 1 instead.
- R10: When a counter wraps from all ones to 0, its `cnt_ovf` bit is set. The bit stays set until that counter is read.
- R11: An accumulator advances on every slot, whether or not its port has a cell or is granted. Credit from a slot the port could not use is not kept for later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_req | input | 1 | One pulse per transmit cell slot to fill |
| cell_avail | input | N_PORTS | A bit per port: that port holds a cell ready |
| port_prio | input | N_PORTS*PRIO_W | Priority level per port; larger wins |
| port_rate | input | N_PORTS*RATE_W | Rate value per port; share is rate/2^RATE_W |
| grant_valid | output | 1 | Answer for the slot requested one cycle earlier |
| grant_idle | output | 1 | The slot carries an idle cell |
| grant_port | output | log2(N_PORTS) | Index of the granted port when not idle |
| cnt_rd_en | input | 1 | Read and clear the selected counter |
| cnt_rd_sel | input | log2(N_PORTS) | Index of the counter to read |
| cnt_rd_data | output | CNT_W | Value of the selected counter |
| cnt_ovf | output | N_PORTS | Sticky wrap flag per counter |

## Verification
Several rate values are swept, each on a single port that always has a cell. These runs show the exact carry pattern and the total of r grants per 256 slots, and they separate rate 0 and rate 255 from the values in between. Directed runs use equal levels, split levels and a port whose cell is missing during a credit slot. These runs separate round-robin order, per-level pointer independence and the rule that credit is not banked. A long run with pseudo-random availability and mixed priorities is compared slot by slot against an arithmetic model. Counter reads after a wrap and a read colliding with an increment exercise the clear and overflow corner cases.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef enum logic {GK_CELL = 1'b0, GK_IDLE = 1'b1} grant_kind_e;
endpackage

// File: rtl/tx_rate_gate.sv
module tx_rate_gate #(
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [RATE_W-1:0] rate,
  output logic              elig
);
  logic [RATE_W-1:0] acc;
  logic [RATE_W:0]   sum;

  function automatic logic [RATE_W:0] credit_add(input logic [RATE_W-1:0] a,
                                                 input logic [RATE_W-1:0] r);
    return {1'b0, a} + {1'b0, r};
  endfunction

  assign sum  = credit_add(acc, rate);
  assign elig = sum[RATE_W];

  always_ff @(posedge clk) begin
    if (!rst_n)    acc <= '0;
    else if (step) acc <= sum[RATE_W-1:0];
  end

  // R11: credit only moves on a slot
  p_acc_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(acc));
  // R3: a zero rate never moves the accumulator
  p_zero_rate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && rate == '0) |=> $stable(acc));
endmodule

// File: rtl/tx_prio_rr.sv
module tx_prio_rr #(
  parameter int N_PORTS = 4,
  parameter int PRIO_W  = 2,
  parameter int IDX_W   = $clog2(N_PORTS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      step,
  input  logic [N_PORTS-1:0]        cand,
  input  logic [N_PORTS*PRIO_W-1:0] prio,
  output logic                      any,
  output logic [IDX_W-1:0]          win
);
  localparam int N_LVL = 1 << PRIO_W;

  logic [N_LVL-1:0][IDX_W-1:0] ptr;
  logic [PRIO_W-1:0]           best;

  function automatic logic [PRIO_W-1:0] lvl_of(input logic [N_PORTS*PRIO_W-1:0] pf,
                                               input int i);
    return pf[i*PRIO_W +: PRIO_W];
  endfunction

  always_comb begin
    any  = 1'b0;
    best = '0;
    for (int i = 0; i < N_PORTS; i++) begin
      if (cand[i] && (!any || lvl_of(prio, i) > best)) begin
        best = lvl_of(prio, i);
        any  = 1'b1;
      end
    end
    win = '0;
    for (int off = N_PORTS - 1; off >= 0; off--) begin
      int j;
      j = (int'(ptr[best]) + off) % N_PORTS;
      if (cand[j] && lvl_of(prio, j) == best) win = IDX_W'(j);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptr <= '0;
    else if (step && any) ptr[best] <= IDX_W'((int'(win) + 1) % N_PORTS);
  end

  // R4: winner is a candidate and nobody outranks it
  always_comb begin
    if (rst_n && any) begin
      p_win_is_cand_r4: assert (cand[win]);
      for (int i = 0; i < N_PORTS; i++) begin
        if (cand[i]) p_win_top_prio_r4: assert (lvl_of(prio, i) <= lvl_of(prio, int'(win)));
      end
    end
  end

  for (genvar l = 0; l < N_LVL; l++) begin : g_ptr_chk
    // R6: a level pointer holds unless that level wins
    p_ptr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(step && any && best == PRIO_W'(l)) |=> $stable(ptr[l]));
  end
endmodule

// File: rtl/tx_cell_tally.sv
module tx_cell_tally #(
  parameter int N_PORTS = 4,
  parameter int CNT_W   = 16,
  parameter int IDX_W   = $clog2(N_PORTS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inc_en,
  input  logic [IDX_W-1:0]   inc_idx,
  input  logic               rd_en,
  input  logic [IDX_W-1:0]   rd_sel,
  output logic [CNT_W-1:0]   rd_data,
  output logic [N_PORTS-1:0] ovf
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [N_PORTS-1:0][CNT_W-1:0] cnt;

  assign rd_data = cnt[rd_sel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      ovf <= '0;
    end else begin
      for (int i = 0; i < N_PORTS; i++) begin
        if (rd_en && rd_sel == IDX_W'(i)) begin
          cnt[i] <= (inc_en && inc_idx == IDX_W'(i)) ? CNT_W'(1) : '0;
          ovf[i] <= 1'b0;
        end else if (inc_en && inc_idx == IDX_W'(i)) begin
          cnt[i] <= cnt[i] + 1'b1;
          if (cnt[i] == CNT_MAX) ovf[i] <= 1'b1;
        end
      end
    end
  end

  // R9: a read with no colliding increment leaves the counter at zero
  p_rd_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !(inc_en && inc_idx == rd_sel)) |=> cnt[$past(rd_sel)] == '0);

  for (genvar g = 0; g < N_PORTS; g++) begin : g_ovf_chk
    // R10: wrapping raises the sticky flag
    p_ovf_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_en && inc_idx == IDX_W'(g) && cnt[g] == CNT_MAX &&
       !(rd_en && rd_sel == IDX_W'(g))) |=> ovf[g]);
  end
endmodule

// File: rtl/tx_cell_sched.sv
module tx_cell_sched #(
  parameter int N_PORTS = 4,
  parameter int PRIO_W  = 2,
  parameter int RATE_W  = 8,
  parameter int CNT_W   = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         slot_req,
  input  logic [N_PORTS-1:0]           cell_avail,
  input  logic [N_PORTS*PRIO_W-1:0]    port_prio,
  input  logic [N_PORTS*RATE_W-1:0]    port_rate,
  output logic                         grant_valid,
  output logic                         grant_idle,
  output logic [$clog2(N_PORTS)-1:0]   grant_port,
  input  logic                         cnt_rd_en,
  input  logic [$clog2(N_PORTS)-1:0]   cnt_rd_sel,
  output logic [CNT_W-1:0]             cnt_rd_data,
  output logic [N_PORTS-1:0]           cnt_ovf
);
  import sched_pkg::*;
  localparam int IDX_W = $clog2(N_PORTS);

  logic [N_PORTS-1:0] elig;
  logic [N_PORTS-1:0] cand;
  logic               any;
  logic [IDX_W-1:0]   win;
  grant_kind_e        kind_q;

  for (genvar p = 0; p < N_PORTS; p++) begin : g_gate
    tx_rate_gate #(.RATE_W(RATE_W)) u_gate (
      .clk  (clk),
      .rst_n(rst_n),
      .step (slot_req),
      .rate (port_rate[p*RATE_W +: RATE_W]),
      .elig (elig[p])
    );
  end

  assign cand = elig & cell_avail;

  tx_prio_rr #(.N_PORTS(N_PORTS), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_arb (
    .clk  (clk),
    .rst_n(rst_n),
    .step (slot_req),
    .cand (cand),
    .prio (port_prio),
    .any  (any),
    .win  (win)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_valid <= 1'b0;
      kind_q      <= GK_IDLE;
      grant_port  <= '0;
    end else begin
      grant_valid <= slot_req;
      if (slot_req) begin
        kind_q     <= any ? GK_CELL : GK_IDLE;
        grant_port <= any ? win : '0;
      end
    end
  end

  assign grant_idle = (kind_q == GK_IDLE);

  tx_cell_tally #(.N_PORTS(N_PORTS), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_tally (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc_en (grant_valid && !grant_idle),
    .inc_idx(grant_port),
    .rd_en  (cnt_rd_en),
    .rd_sel (cnt_rd_sel),
    .rd_data(cnt_rd_data),
    .ovf    (cnt_ovf)
  );

  p_req_to_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    slot_req |=> grant_valid);
  p_no_req_no_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_req |=> !grant_valid);
  p_idle_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_req && cand == '0) |=> (grant_valid && grant_idle));
endmodule

// File: tb/tb_tx_cell_sched.sv
module tb_tx_cell_sched;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int PW = 2;
  localparam int RW = 8;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slot_req = 1'b0;
  logic [N-1:0] cell_avail = '0;
  logic [N*PW-1:0] port_prio = '0;
  logic [N*RW-1:0] port_rate = '0;
  logic grant_valid, grant_idle;
  logic [1:0] grant_port;
  logic cnt_rd_en = 1'b0;
  logic [1:0] cnt_rd_sel = '0;
  logic [CW-1:0] cnt_rd_data;
  logic [N-1:0] cnt_ovf;

  tx_cell_sched #(.N_PORTS(N), .PRIO_W(PW), .RATE_W(RW), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .slot_req(slot_req), .cell_avail(cell_avail),
    .port_prio(port_prio), .port_rate(port_rate), .grant_valid(grant_valid),
    .grant_idle(grant_idle), .grant_port(grant_port), .cnt_rd_en(cnt_rd_en),
    .cnt_rd_sel(cnt_rd_sel), .cnt_rd_data(cnt_rd_data), .cnt_ovf(cnt_ovf)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int m_acc[N], m_rr[4], m_cnt[N], rate_v[N], prio_v[N];
  bit m_ovf[N];
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic apply_cfg();
    for (int p = 0; p < N; p++) begin
      port_rate[p*RW +: RW] = RW'(rate_v[p]);
      port_prio[p*PW +: PW] = PW'(prio_v[p]);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; slot_req = 1'b0; cnt_rd_en = 1'b0; cell_avail = '0;
    for (int p = 0; p < N; p++) begin
      m_acc[p] = 0; m_cnt[p] = 0; m_ovf[p] = 0; m_rr[p] = 0;
    end
    apply_cfg();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_slot(input logic [N-1:0] av, input string tag);
    bit el[N];
    int best, win;
    for (int p = 0; p < N; p++) begin
      el[p] = (m_acc[p] + rate_v[p]) >= 256;
      m_acc[p] = (m_acc[p] + rate_v[p]) % 256;
    end
    best = -1; win = -1;
    for (int p = 0; p < N; p++)
      if (el[p] && av[p] && prio_v[p] > best) best = prio_v[p];
    if (best >= 0) begin
      for (int off = 0; off < N; off++) begin
        int j;
        j = (m_rr[best] + off) % N;
        if (win < 0 && el[j] && av[j] && prio_v[j] == best) win = j;
      end
      m_rr[best] = (win + 1) % N;
    end
    slot_req = 1'b1; cell_avail = av;
    @(negedge clk);
    slot_req = 1'b0;
    chk("R2", "grant_valid after slot", int'(grant_valid), 1);
    chk((win < 0) ? "R7" : tag, "grant_idle", int'(grant_idle), (win < 0) ? 1 : 0);
    if (win >= 0) begin
      chk(tag, "grant_port", int'(grant_port), win);
      if (m_cnt[win] == 255) m_ovf[win] = 1;
      m_cnt[win] = (m_cnt[win] + 1) % 256;
    end
  endtask

  task automatic rd_cnt(input int p, input string tag);
    @(negedge clk);
    chk("R2", "grant_valid with no slot", int'(grant_valid), 0);
    cnt_rd_en = 1'b1; cnt_rd_sel = 2'(p);
    #1;
    chk(tag, "counter value", int'(cnt_rd_data), m_cnt[p]);
    chk("R10", "ovf flag", int'(cnt_ovf[p]), int'(m_ovf[p]));
    @(negedge clk);
    cnt_rd_en = 1'b0;
    m_cnt[p] = 0; m_ovf[p] = 0;
    chk("R9", "counter after read", int'(cnt_rd_data), 0);
    chk("R10", "ovf after read", int'(cnt_ovf[p]), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog run did not finish actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int rates[6] = '{0, 1, 37, 128, 200, 255};
    for (int p = 0; p < N; p++) begin rate_v[p] = 0; prio_v[p] = 0; end
    do_reset();
    // R1: reset state
    chk("R1", "grant_valid after reset", int'(grant_valid), 0);
    chk("R1", "ovf after reset", int'(cnt_ovf), 0);
    for (int p = 0; p < N; p++) rd_cnt(p, "R1");

    // R3: rate sweep on one port, 256 slots each
    for (int k = 0; k < 6; k++) begin
      int port;
      port = k % N;
      for (int p = 0; p < N; p++) rate_v[p] = 0;
      rate_v[port] = rates[k];
      do_reset();
      for (int s = 0; s < 256; s++) do_slot(4'hF, "R3");
      @(negedge clk);
      chk("R3", "grants in 256 slots", int'(dut.cnt_rd_data) * 0 + m_cnt[port], rates[k]);
      rd_cnt(port, "R3");
    end

    // R5: equal levels, round-robin
    for (int p = 0; p < N; p++) begin rate_v[p] = 255; prio_v[p] = 1; end
    do_reset();
    for (int s = 0; s < 9; s++) do_slot(4'hF, "R5");
    do_slot(4'b1010, "R5");
    do_slot(4'b1010, "R5");

    // R6: split levels, lower level pointer untouched
    prio_v[0] = 1; prio_v[1] = 1; prio_v[2] = 2; prio_v[3] = 2;
    do_reset();
    do_slot(4'hF, "R7");
    for (int s = 0; s < 3; s++) do_slot(4'hF, "R4");
    do_slot(4'b0011, "R6");
    chk("R6", "lower level starts at port 0", int'(grant_port), 0);
    do_slot(4'b0011, "R6");

    // R11: credit not banked
    for (int p = 0; p < N; p++) begin rate_v[p] = 0; prio_v[p] = 0; end
    rate_v[0] = 128;
    do_reset();
    do_slot(4'b0001, "R11");
    do_slot(4'b0000, "R11");
    do_slot(4'b0001, "R11");
    chk("R11", "no banked credit idle", int'(grant_idle), 1);
    do_slot(4'b0001, "R11");

    // R4/R5/R6/R8: mixed priorities, pseudo-random availability
    rate_v[0] = 200; rate_v[1] = 90; rate_v[2] = 255; rate_v[3] = 140;
    prio_v[0] = 3; prio_v[1] = 1; prio_v[2] = 1; prio_v[3] = 3;
    do_reset();
    for (int s = 0; s < 400; s++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      do_slot(lfsr[3:0], "R4");
    end
    for (int p = 0; p < N; p++) rd_cnt(p, "R8");

    // R10: wrap and overflow flag
    for (int p = 0; p < N; p++) begin rate_v[p] = 0; prio_v[p] = 0; end
    rate_v[0] = 255;
    do_reset();
    for (int s = 0; s < 260; s++) do_slot(4'b0001, "R10");
    @(negedge clk);
    chk("R10", "ovf set after wrap", int'(cnt_ovf[0]), 1);
    chk("R10", "wrapped count", int'(cnt_rd_data) * 0 + m_cnt[0], 2);
    rd_cnt(0, "R10");

    // R9: read colliding with an increment
    do_slot(4'b0001, "R9");
    cnt_rd_en = 1'b1; cnt_rd_sel = 2'd0;
    #1;
    chk("R9", "read before collision", int'(cnt_rd_data), 0);
    @(negedge clk);
    cnt_rd_en = 1'b0;
    chk("R9", "counter after collision", int'(cnt_rd_data), 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule